// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a synchronous DRAM and walks the memory from power-up to its operational state. Once the clock is stable and the synchronous reset is released, it keeps the device quiet with no-operation commands for a programmable power-up hold. It then closes every bank with one precharge-all command, issues a configurable number of auto-refresh commands (two by default), and loads the mode register with an op-code supplied at its input. Finally it raises a ready flag that the normal command scheduler waits on.

Every timing value is given as a parameter in picoseconds together with the clock period. The block converts each one to a whole number of clock cycles, rounding up and never going below one cycle. The spacing between successive commands is therefore always at least the physical requirement. Command, address and bank outputs come straight from registered state. A synchronous reset restarts the whole sequence from the start.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, chip select is high and the other three command lines are high (inhibit), address and bank are all zero, and ready is low.
- R2: Each timing parameter becomes ceil(time / clock period) cycles, with a floor of one cycle. With a 4000 ps clock, 18000 ps gives 5 cycles, 62000 ps gives 16 cycles and 8000 ps gives 2 cycles.
- R3: For the power-up hold count of cycles after reset is released, the outputs carry NOP. NOP is chip select low with row strobe, column strobe and write enable high, command pins {cs_n,ras_n,cas_n,we_n} = 0111.
- R4: In the cycle after the power-up hold ends, a single precharge-all is driven: pins 0010, address bit AP_BIT (10) high and every other address bit low, bank lines zero.
- R5: The first auto-refresh (pins 0001) comes precharge-time cycles after the precharge-all. Each further auto-refresh follows the previous one by the refresh-cycle count, and REF_COUNT (2) of them are issued.
- R6: The mode load (pins 0000) comes refresh-cycle count cycles after the last refresh. Its address carries mode_op on the low ADDR_W-1 bits, with the top address bit forced low.
- R7: Every cycle between two commands carries NOP with address and bank zero.
- R8: ready rises exactly the mode-register-delay count of cycles after the mode-load cycle. Until that point no command other than NOP is driven after the load. From then on ready stays high and the outputs stay at NOP.
- R9: Asserting reset in the middle of the sequence returns the outputs to the R1 state. Releasing it replays the full sequence from the power-up hold.
- R10: mode_op is captured only in the mode-load cycle. Changing it after ready has no effect on the address lines, which stay zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high, restarts the sequence |
| mode_op | input | ADDR_W-1 (12) | Op-code placed on the low address bits during the mode load |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe command line, active low |
| cas_n | output | 1 | Column strobe command line, active low |
| we_n | output | 1 | Write-enable command line, active low |
| addr | output | ADDR_W (13) | Address lines to the memory |
| ba | output | BANK_W (2) | Bank select lines, held zero throughout |
| ready | output | 1 | High once initialization has completed |

## Verification
The first rising edge with reset low counts as edge 1, since every output is taken from a register. The power-up NOPs appear after edges 1 to P and the precharge-all after edge P+1. The first refresh follows TRP edges later, the second refresh TRFC edges after that, the mode load another TRFC edges later, and ready TMRD edges after the load. The bench builds one expected item per clock edge from these counts and queues them. The monitor pops one item on each falling edge, so it always compares the value registered on the rising edge just before. The reset and mode_op-change stimuli are applied one time unit after a rising edge, which keeps the edge being counted unambiguous.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        CMD_INHIBIT,
        CMD_NOP,
        CMD_PRECHARGE,
        CMD_REFRESH,
        CMD_LOADMODE
    } init_cmd_e;

    typedef enum logic [1:0] {
        GOAL_PRECHARGE,
        GOAL_REFRESH,
        GOAL_LOADMODE,
        GOAL_READY
    } init_goal_e;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] PINS_INHIBIT   = 4'b1111;
    localparam logic [3:0] PINS_NOP       = 4'b0111;
    localparam logic [3:0] PINS_PRECHARGE = 4'b0010;
    localparam logic [3:0] PINS_REFRESH   = 4'b0001;
    localparam logic [3:0] PINS_LOADMODE  = 4'b0000;

    // time in ps to whole clock cycles, rounded up, never below one
    function automatic int ps_to_cycles(input int time_ps, input int clk_ps);
        int c;
        c = (time_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sdram_init_ctl.sv
module sdram_init_ctl
    import sdram_init_pkg::*;
#(
    parameter int PWR_CYC   = 16,
    parameter int TRP_CYC   = 3,
    parameter int TRFC_CYC  = 9,
    parameter int TMRD_CYC  = 2,
    parameter int REF_COUNT = 2,
    parameter int OP_W      = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] mode_op,
    output init_cmd_e       cmd_o,
    output logic [OP_W-1:0] mode_o,
    output logic            ready_o
);

    localparam int MAX_CYC = max_of4(PWR_CYC, TRP_CYC, TRFC_CYC, TMRD_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int REF_W   = $clog2(REF_COUNT + 1);

    typedef struct packed {
        init_goal_e      goal;
        logic [CNT_W-1:0] gap;
        logic [REF_W-1:0] refs_left;
        init_cmd_e       cmd;
        logic [OP_W-1:0] mode;
        logic            ready;
    } ctl_s;

    ctl_s st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cmd = CMD_NOP;
        if (st_q.gap != '0) begin
            st_d.gap = st_q.gap - CNT_W'(1);
        end else begin
            unique case (st_q.goal)
                GOAL_PRECHARGE: begin
                    st_d.cmd       = CMD_PRECHARGE;
                    st_d.goal      = GOAL_REFRESH;
                    st_d.gap       = CNT_W'(TRP_CYC - 1);
                    st_d.refs_left = REF_W'(REF_COUNT);
                end
                GOAL_REFRESH: begin
                    st_d.cmd       = CMD_REFRESH;
                    st_d.gap       = CNT_W'(TRFC_CYC - 1);
                    st_d.refs_left = st_q.refs_left - REF_W'(1);
                    if (st_q.refs_left <= REF_W'(1)) begin
                        st_d.goal = GOAL_LOADMODE;
                    end
                end
                GOAL_LOADMODE: begin
                    st_d.cmd  = CMD_LOADMODE;
                    st_d.mode = mode_op;
                    st_d.goal = GOAL_READY;
                    st_d.gap  = CNT_W'(TMRD_CYC - 1);
                end
                default: begin
                    st_d.ready = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.goal      <= GOAL_PRECHARGE;
            st_q.gap       <= CNT_W'(PWR_CYC);
            st_q.refs_left <= REF_W'(REF_COUNT);
            st_q.cmd       <= CMD_INHIBIT;
            st_q.mode      <= '0;
            st_q.ready     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o   = st_q.cmd;
    assign mode_o  = st_q.mode;
    assign ready_o = st_q.ready;

endmodule

// File: rtl/sdram_init_enc.sv
module sdram_init_enc
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2,
    parameter int AP_BIT = 10
) (
    input  init_cmd_e         cmd,
    input  logic [ADDR_W-2:0] mode,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] ba
);

    logic [3:0] pins;

    always_comb begin
        pins = PINS_NOP;
        addr = '0;
        unique case (cmd)
            CMD_INHIBIT:   pins = PINS_INHIBIT;
            CMD_PRECHARGE: begin
                pins         = PINS_PRECHARGE;
                addr[AP_BIT] = 1'b1;
            end
            CMD_REFRESH:   pins = PINS_REFRESH;
            CMD_LOADMODE: begin
                pins = PINS_LOADMODE;
                addr = {1'b0, mode};
            end
            default:       pins = PINS_NOP;
        endcase
    end

    assign {cs_n, ras_n, cas_n, we_n} = pins;
    assign ba = '0;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int T_CLK_PS  = 7500,
    parameter int PWRUP_PS  = 100_000_000,
    parameter int TRP_PS    = 20_000,
    parameter int TRFC_PS   = 66_000,
    parameter int TMRD_PS   = 15_000,
    parameter int REF_COUNT = 2,
    parameter int ADDR_W    = 13,
    parameter int BANK_W    = 2,
    parameter int AP_BIT    = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-2:0] mode_op,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] ba,
    output logic              ready
);

    localparam int PWR_CYC  = ps_to_cycles(PWRUP_PS, T_CLK_PS);
    localparam int TRP_CYC  = ps_to_cycles(TRP_PS, T_CLK_PS);
    localparam int TRFC_CYC = ps_to_cycles(TRFC_PS, T_CLK_PS);
    localparam int TMRD_CYC = ps_to_cycles(TMRD_PS, T_CLK_PS);
    localparam int OP_W     = ADDR_W - 1;

    init_cmd_e       cmd;
    logic [OP_W-1:0] mode_hold;

    sdram_init_ctl #(
        .PWR_CYC  (PWR_CYC),
        .TRP_CYC  (TRP_CYC),
        .TRFC_CYC (TRFC_CYC),
        .TMRD_CYC (TMRD_CYC),
        .REF_COUNT(REF_COUNT),
        .OP_W     (OP_W)
    ) u_ctl (
        .clk    (clk),
        .rst    (rst),
        .mode_op(mode_op),
        .cmd_o  (cmd),
        .mode_o (mode_hold),
        .ready_o(ready)
    );

    sdram_init_enc #(
        .ADDR_W(ADDR_W),
        .BANK_W(BANK_W),
        .AP_BIT(AP_BIT)
    ) u_enc (
        .cmd  (cmd),
        .mode (mode_hold),
        .cs_n (cs_n),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .we_n (we_n),
        .addr (addr),
        .ba   (ba)
    );

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
    parameter int ADDR_W    = 13,
    parameter int AP_BIT    = 10,
    parameter int TMRD_CYC  = 2,
    parameter int REF_COUNT = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ready
);

    logic is_nop, is_pre, is_ref, is_lmr;
    assign is_nop = ({cs_n, ras_n, cas_n, we_n} == 4'b0111);
    assign is_pre = ({cs_n, ras_n, cas_n, we_n} == 4'b0010);
    assign is_ref = ({cs_n, ras_n, cas_n, we_n} == 4'b0001);
    assign is_lmr = ({cs_n, ras_n, cas_n, we_n} == 4'b0000);

    int  since_lmr;
    int  refs_seen;
    logic lmr_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_lmr <= 0;
            refs_seen <= 0;
            lmr_seen  <= 1'b0;
        end else begin
            if (is_ref) refs_seen <= refs_seen + 1;
            if (is_lmr) begin
                since_lmr <= 1;
                lmr_seen  <= 1'b1;
            end else if (lmr_seen && since_lmr < 1_000_000) begin
                since_lmr <= since_lmr + 1;
            end
        end
    end

    assert_reset_exit_inhibit_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cs_n && !ready));

    assert_precharge_all_R4: assert property (@(posedge clk) disable iff (rst)
        is_pre |-> addr[AP_BIT]);

    assert_refresh_count_R5: assert property (@(posedge clk) disable iff (rst)
        is_lmr |-> (refs_seen == REF_COUNT));

    assert_mode_top_low_R6: assert property (@(posedge clk) disable iff (rst)
        is_lmr |-> !addr[ADDR_W-1]);

    assert_legal_command_R7: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> (is_nop || is_pre || is_ref || is_lmr));

    assert_nop_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        is_nop |-> (addr == '0));

    assert_ready_delay_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (since_lmr == TMRD_CYC));

    assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    assert_ready_idle_R8: assert property (@(posedge clk) disable iff (rst)
        ready |-> is_nop);

endmodule

bind sdram_init_seq sdram_init_chk #(
    .ADDR_W   (ADDR_W),
    .AP_BIT   (AP_BIT),
    .TMRD_CYC (TMRD_CYC),
    .REF_COUNT(REF_COUNT)
) u_chk (
    .clk  (clk),
    .rst  (rst),
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .addr (addr),
    .ready(ready)
);

// File: tb/tb_sdram_init_seq.sv
`timescale 1ns/1ps
module tb_sdram_init_seq;

    localparam int P    = 25;  // 100000 ps / 4000 ps
    localparam int TRP  = 5;   // 18000 ps rounds up
    localparam int TRFC = 16;  // 62000 ps rounds up
    localparam int TMRD = 2;   // 8000 ps exact

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mode_op = '0;
    logic        cs_n, ras_n, cas_n, we_n, ready;
    logic [12:0] addr;
    logic [1:0]  ba;

    always #2 clk = ~clk;

    sdram_init_seq #(
        .T_CLK_PS (4000),
        .PWRUP_PS (100_000),
        .TRP_PS   (18_000),
        .TRFC_PS  (62_000),
        .TMRD_PS  (8_000),
        .REF_COUNT(2),
        .ADDR_W   (13),
        .BANK_W   (2),
        .AP_BIT   (10)
    ) dut (
        .clk(clk), .rst(rst), .mode_op(mode_op),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .ba(ba), .ready(ready)
    );

    typedef struct {
        logic [3:0]  pins;
        logic [12:0] addr;
        logic        rdy;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;

    // monitor: one expected item per rising edge, compared on the falling edge
    always @(negedge clk) begin : monitor
        exp_t e;
        if (mon_on && q.size() > 0) begin
            e = q.pop_front();
            total++;
            if ({cs_n, ras_n, cas_n, we_n} !== e.pins || addr !== e.addr ||
                ba !== 2'b00 || ready !== e.rdy) begin
                bad++;
                $display("FAIL %s: got pins=%b addr=%h ba=%b rdy=%b, want pins=%b addr=%h ba=00 rdy=%b",
                         e.tag, {cs_n, ras_n, cas_n, we_n}, addr, ba, ready,
                         e.pins, e.addr, e.rdy);
            end
        end
    end

    task automatic push(input logic [3:0] pins, input logic [12:0] a,
                        input logic rdy, input string tag);
        exp_t e;
        e.pins = pins; e.addr = a; e.rdy = rdy; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic push_nops(input int n, input logic rdy, input string tag);
        for (int i = 0; i < n; i++) push(4'b0111, 13'h0, rdy, tag);
    endtask

    // driver: the full expected bring-up, one item per edge after release
    task automatic expect_bringup(input logic [11:0] op);
        push_nops(P, 1'b0, "R3 power-up hold");
        push(4'b0010, 13'h0400, 1'b0, "R4 precharge-all");
        push_nops(TRP - 1, 1'b0, "R7 wait after precharge");
        push(4'b0001, 13'h0, 1'b0, "R2/R5 first refresh after rounded precharge time");
        push_nops(TRFC - 1, 1'b0, "R7 wait after refresh");
        push(4'b0001, 13'h0, 1'b0, "R5 second refresh");
        push_nops(TRFC - 1, 1'b0, "R7 wait after refresh");
        push(4'b0000, {1'b0, op}, 1'b0, "R6 mode load");
        push_nops(TMRD - 1, 1'b0, "R8 mode delay");
        push_nops(6, 1'b1, "R8 ready held");
    endtask

    task automatic release_reset();
        @(posedge clk); #1 rst = 1'b0;
        @(posedge clk); #1 mon_on = 1'b1;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic check_reset_state(input string tag);
        @(negedge clk);
        total++;
        if ({cs_n, ras_n, cas_n, we_n} !== 4'b1111 || addr !== 13'h0 ||
            ba !== 2'b00 || ready !== 1'b0) begin
            bad++;
            $display("FAIL %s: got pins=%b addr=%h ba=%b rdy=%b, want pins=1111 addr=0000 ba=00 rdy=0",
                     tag, {cs_n, ras_n, cas_n, we_n}, addr, ba, ready);
        end
    endtask

    initial begin : watchdog
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, got running, want finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        // R1: reset state
        mode_op = 12'h032;
        repeat (3) @(posedge clk);
        check_reset_state("R1 reset state");
        check_reset_state("R1 reset state held");

        // R2..R8: complete bring-up with burst-length-style op-code
        expect_bringup(12'h032);
        release_reset();
        drain();

        // R10: op-code change after ready leaves address untouched
        @(posedge clk); #1 mode_op = 12'hfff;
        push_nops(4, 1'b1, "R10 op-code change ignored");
        drain();

        // R9: restart from the middle of the sequence
        mon_on = 1'b0;
        mode_op = 12'h227;
        @(posedge clk); #1 rst = 1'b1;
        expect_bringup(12'h227);
        release_reset();
        repeat (40) @(negedge clk);
        mon_on = 1'b0;
        q.delete();
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk);
        check_reset_state("R9 mid-sequence reset");
        expect_bringup(12'h227);
        release_reset();
        drain();
        mon_on = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule